// File: doc/BRIEF.md
# Hierarchical Encoded Interrupt Status Unit

This block collects interrupt sources from three priority groups (4 critical, 17 main and 32 peripheral) and a 32-entry DMA task bank. It presents one encoded status word. For each group, the word holds a valid flag and the index of the winning source. Inside a group, the lowest-numbered source that is enabled and pending wins. Between groups the order is fixed: critical first, then main, then peripheral. A two-bit class output reports which group is currently the most urgent.

Main and peripheral sources are level inputs and are gated by mask registers in which a 1 disables a source. The mask bits are stored in reversed order. The DMA bank latches task requests into a pending register that software clears by writing 1s. The bank has its own mask, and its combined result becomes peripheral source 0. When anything in the peripheral group is pending, the block feeds that fact back up into one of two places, chosen by a route bit in the control register:
- main index 4, for low-priority routing;
- critical index 2, for high-priority routing.

Critical sources 0, 1 and 3 are latched. Software acknowledges the one currently reported by writing 1 to bit 10 of the status word.

Top module: `hirq_status_unit`

## Requirements
- R1: While reset is high and after it drops, the main mask reads 0x0001FFFF. The peripheral mask and the DMA mask read 0xFFFFFFFF. The DMA pending register reads 0. All critical flags are clear, the status word (address 0) reads 0, and irq_req is 0.
- R2: A high level on crit_src[i] (i = 0, 1, 3) sets a latched critical flag at the next clock edge. The flag stays set until it is acknowledged. In the status word, bit 10 flags a pending critical source and bits 9:8 hold the lowest pending critical index.
- R3: Main source i is enabled when bit 16-i of the main mask (address 1, bits 16:0, 1 = disabled) is 0. Status bit 21 flags an enabled, high main source, and bits 20:16 hold the lowest such index.
- R4: Peripheral source i is enabled when bit 31-i of the peripheral mask (address 2, 1 = disabled) is 0. Status bit 29 flags an enabled, high peripheral source, and bits 28:24 hold the lowest such index.
- R5: Each high dma_req[k] sets DMA pending bit k. Writing 1s to address 3 clears the matching pending bits. If a bit is requested and cleared in the same cycle, the request wins.
- R6: The DMA mask is at address 4, with 1 = disabled. dma_valid and dma_idx report the lowest pending, enabled DMA bit. That result drives peripheral source 0, and the peri_src[0] input has no effect.
- R7: Control bit 0 is at address 5 and is named route. When route is 0, a pending peripheral group drives main source 4. When route is 1, it drives critical source 2, and critical source 2 is not latched. The inputs main_src[4] and crit_src[2] have no effect.
- R8: A write to address 0 with bit 10 set clears the latched flag of the currently reported critical index. A write to address 0 with bit 10 clear changes nothing.
- R9: irq_class is 3 when a critical source is pending, otherwise 2 when a main source is, otherwise 1 when a peripheral source is, otherwise 0. irq_req is 1 whenever irq_class is nonzero.
- R10: Masks and the control bit read back what was written. Bits 31:17 of the main mask and bits 31:1 of control read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| crit_src | input | 4 | Critical source levels |
| main_src | input | 17 | Main source levels |
| peri_src | input | 32 | Peripheral source levels |
| dma_req | input | 32 | DMA task request levels |
| irq_req | output | 1 | Any group pending |
| irq_class | output | 2 | Most urgent pending group |
| dma_valid | output | 1 | A DMA bit is pending and enabled |
| dma_idx | output | 5 | Lowest pending enabled DMA bit |

## Verification
The main and peripheral groups are first driven with two sources raised together while their masks are still closed. The masks are then opened one source at a time. This separates the lowest-index choice from the reversed mask bit mapping.

The peripheral group is then routed both ways through the cascade. The bench checks that main index 4 and critical index 2 each appear only under their own route setting, and that the matching source inputs are ignored.

For the DMA bank, the bench:
- pulses requests and watches them latch;
- clears bits one at a time by writing 1s;
- holds a request high during its own clear, to show that the request wins.

Two critical sources are latched and acknowledged in turn. A write to the status word without bit 10 must leave them untouched.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int DW      = 32;
    localparam int AW      = 3;
    localparam int N_CRIT  = 4;
    localparam int N_MAIN  = 17;
    localparam int N_PERI  = 32;
    localparam int N_DMA   = 32;
    localparam int CRIT_IW = $clog2(N_CRIT);
    localparam int GRP_IW  = 5;

    // encoded status field positions (decoded by software)
    localparam int ST_CRIT_V   = 10;
    localparam int ST_CRIT_LSB = 8;
    localparam int ST_MAIN_V   = 21;
    localparam int ST_MAIN_LSB = 16;
    localparam int ST_PERI_V   = 29;
    localparam int ST_PERI_LSB = 24;

    // fixed cascade indices
    localparam int CASC_CRIT = 2;
    localparam int CASC_MAIN = 4;
    localparam int CASC_PERI = 0;

    typedef enum logic [AW-1:0] {
        A_STATUS = 3'd0,
        A_MMASK  = 3'd1,
        A_PMASK  = 3'd2,
        A_DPEND  = 3'd3,
        A_DMASK  = 3'd4,
        A_CTRL   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_PERI = 2'd1,
        CLS_MAIN = 2'd2,
        CLS_CRIT = 2'd3
    } irq_class_e;

    typedef struct packed {
        logic              valid;
        logic [GRP_IW-1:0] idx;
    } grp_hit_t;

    function automatic logic [DW-1:0] pack_status(grp_hit_t c, grp_hit_t m, grp_hit_t p);
        logic [DW-1:0] s;
        s = '0;
        s[ST_CRIT_V] = c.valid;
        s[ST_CRIT_LSB +: CRIT_IW] = c.idx[CRIT_IW-1:0];
        s[ST_MAIN_V] = m.valid;
        s[ST_MAIN_LSB +: GRP_IW] = m.idx;
        s[ST_PERI_V] = p.valid;
        s[ST_PERI_LSB +: GRP_IW] = p.idx;
        return s;
    endfunction

    function automatic irq_class_e pick_class(grp_hit_t c, grp_hit_t m, grp_hit_t p);
        if (c.valid)      return CLS_CRIT;
        else if (m.valid) return CLS_MAIN;
        else if (p.valid) return CLS_PERI;
        else              return CLS_NONE;
    endfunction
endpackage

// File: rtl/hirq_lsb_enc.sv
module hirq_lsb_enc #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    // R3: reported index is set and nothing below it is set
    assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (vec[idx] && ((vec & ((W'(1) << idx) - W'(1))) == '0)));

    assert_none_means_empty_R3: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (vec == '0));
endmodule

// File: rtl/hirq_dma_bank.sv
module hirq_dma_bank #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          clr_we,
    input  logic [N-1:0]  clr_bits,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  mask,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N-1:0] pend_d;

    always_comb begin
        pend_d = pend;
        if (clr_we) pend_d = pend_d & ~clr_bits;
        pend_d = pend_d | req;          // a new request beats a clear
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= pend_d;
            if (mask_we) mask <= mask_wdata;
        end
    end

    hirq_lsb_enc #(.W(N), .IW(IW)) u_enc (
        .clk(clk), .rst(rst), .vec(pend & ~mask), .valid(valid), .idx(idx)
    );

    // R5: without a clear, pending bits never drop
    assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((pend & $past(pend)) == $past(pend)));

    // R5: a request is pending on the next cycle
    assert_req_latch_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(req)) == $past(req)));

    // R6: reported DMA hit is pending and enabled
    assert_hit_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        valid |-> (pend[idx] && !mask[idx]));
endmodule

// File: rtl/hirq_status_unit.sv
module hirq_status_unit
    import hirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic [N_CRIT-1:0]    crit_src,
    input  logic [N_MAIN-1:0]    main_src,
    input  logic [N_PERI-1:0]    peri_src,
    input  logic [N_DMA-1:0]     dma_req,
    output logic                 irq_req,
    output logic [1:0]           irq_class,
    output logic                 dma_valid,
    output logic [GRP_IW-1:0]    dma_idx
);
    localparam int DMA_IW  = $clog2(N_DMA);
    localparam int MAIN_IW = $clog2(N_MAIN);
    localparam int PERI_IW = $clog2(N_PERI);

    logic [N_MAIN-1:0] mmask_q;
    logic [N_PERI-1:0] pmask_q;
    logic              route_q;
    logic [N_CRIT-1:0] crit_pend;

    logic [N_DMA-1:0]  dma_pend, dma_mask;
    logic [DMA_IW-1:0] dma_idx_w;

    logic [N_CRIT-1:0] crit_vec;
    logic [N_MAIN-1:0] main_vec;
    logic [N_PERI-1:0] peri_vec;

    logic               crit_v, main_v, peri_v;
    logic [CRIT_IW-1:0] crit_i;
    logic [MAIN_IW-1:0] main_i;
    logic [PERI_IW-1:0] peri_i;
    grp_hit_t           crit_hit, main_hit, peri_hit;

    reg_addr_e addr_e;
    logic      wr_status, wr_mmask, wr_pmask, wr_dpend, wr_dmask, wr_ctrl;
    logic      crit_ack;

    assign addr_e    = reg_addr_e'(reg_addr);
    assign wr_status = reg_we && (addr_e == A_STATUS);
    assign wr_mmask  = reg_we && (addr_e == A_MMASK);
    assign wr_pmask  = reg_we && (addr_e == A_PMASK);
    assign wr_dpend  = reg_we && (addr_e == A_DPEND);
    assign wr_dmask  = reg_we && (addr_e == A_DMASK);
    assign wr_ctrl   = reg_we && (addr_e == A_CTRL);
    assign crit_ack  = wr_status && reg_wdata[ST_CRIT_V] && crit_v;

    // ---------------- mask / control registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            mmask_q <= '1;
            pmask_q <= '1;
            route_q <= 1'b0;
        end else begin
            if (wr_mmask) mmask_q <= reg_wdata[N_MAIN-1:0];
            if (wr_pmask) pmask_q <= reg_wdata[N_PERI-1:0];
            if (wr_ctrl)  route_q <= reg_wdata[0];
        end
    end

    // ---------------- DMA task bank ----------------
    hirq_dma_bank #(.N(N_DMA), .IW(DMA_IW)) u_dma (
        .clk(clk), .rst(rst), .req(dma_req),
        .clr_we(wr_dpend), .clr_bits(reg_wdata[N_DMA-1:0]),
        .mask_we(wr_dmask), .mask_wdata(reg_wdata[N_DMA-1:0]),
        .pend(dma_pend), .mask(dma_mask),
        .valid(dma_valid), .idx(dma_idx_w)
    );
    assign dma_idx = GRP_IW'(dma_idx_w);

    // ---------------- peripheral group (reversed mask) ----------------
    for (genvar i = 0; i < N_PERI; i++) begin : g_peri
        if (i == CASC_PERI) begin : g_casc
            assign peri_vec[i] = dma_valid & ~pmask_q[N_PERI-1-i];
        end else begin : g_src
            assign peri_vec[i] = peri_src[i] & ~pmask_q[N_PERI-1-i];
        end
    end

    hirq_lsb_enc #(.W(N_PERI), .IW(PERI_IW)) u_peri_enc (
        .clk(clk), .rst(rst), .vec(peri_vec), .valid(peri_v), .idx(peri_i)
    );

    // ---------------- main group (reversed mask) ----------------
    for (genvar i = 0; i < N_MAIN; i++) begin : g_main
        if (i == CASC_MAIN) begin : g_casc
            assign main_vec[i] = peri_v & ~route_q & ~mmask_q[N_MAIN-1-i];
        end else begin : g_src
            assign main_vec[i] = main_src[i] & ~mmask_q[N_MAIN-1-i];
        end
    end

    hirq_lsb_enc #(.W(N_MAIN), .IW(MAIN_IW)) u_main_enc (
        .clk(clk), .rst(rst), .vec(main_vec), .valid(main_v), .idx(main_i)
    );

    // ---------------- critical group (latched, cascade live) ----------------
    for (genvar i = 0; i < N_CRIT; i++) begin : g_crit
        if (i == CASC_CRIT) begin : g_casc
            always_ff @(posedge clk) crit_pend[i] <= 1'b0;
            assign crit_vec[i] = peri_v & route_q;
        end else begin : g_latch
            always_ff @(posedge clk) begin
                if (rst)
                    crit_pend[i] <= 1'b0;
                else
                    crit_pend[i] <= (crit_pend[i] & ~(crit_ack && (crit_i == CRIT_IW'(i))))
                                    | crit_src[i];
            end
            assign crit_vec[i] = crit_pend[i];
        end
    end

    hirq_lsb_enc #(.W(N_CRIT), .IW(CRIT_IW)) u_crit_enc (
        .clk(clk), .rst(rst), .vec(crit_vec), .valid(crit_v), .idx(crit_i)
    );

    // ---------------- encoding and read-back ----------------
    assign crit_hit = '{valid: crit_v, idx: GRP_IW'(crit_i)};
    assign main_hit = '{valid: main_v, idx: GRP_IW'(main_i)};
    assign peri_hit = '{valid: peri_v, idx: GRP_IW'(peri_i)};

    assign irq_class = pick_class(crit_hit, main_hit, peri_hit);
    assign irq_req   = (irq_class != CLS_NONE);

    always_comb begin
        case (addr_e)
            A_STATUS: reg_rdata = pack_status(crit_hit, main_hit, peri_hit);
            A_MMASK:  reg_rdata = DW'(mmask_q);
            A_PMASK:  reg_rdata = DW'(pmask_q);
            A_DPEND:  reg_rdata = DW'(dma_pend);
            A_DMASK:  reg_rdata = DW'(dma_mask);
            A_CTRL:   reg_rdata = DW'(route_q);
            default:  reg_rdata = '0;
        endcase
    end

    // R1: masks closed and critical flags clear right after reset
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mmask_q == '1 && pmask_q == '1 && crit_pend == '0));

    // R2: latched critical flags only drop after an acknowledge
    assert_crit_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !crit_ack |=> ((crit_pend & $past(crit_pend)) == $past(crit_pend)));

    // R8: acknowledge clears the reported critical flag when its source is idle
    assert_crit_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (crit_ack && crit_i != CRIT_IW'(CASC_CRIT) && !crit_src[crit_i])
        |=> !crit_pend[$past(crit_i)]);

    // R7: main index 4 only appears through the low-priority route
    assert_main_cascade_R7: assert property (@(posedge clk) disable iff (rst)
        (main_v && main_i == MAIN_IW'(CASC_MAIN)) |-> (peri_v && !route_q));

    // R7: critical index 2 only appears through the high-priority route
    assert_crit_cascade_R7: assert property (@(posedge clk) disable iff (rst)
        (crit_v && crit_i == CRIT_IW'(CASC_CRIT)) |-> (peri_v && route_q));

    // R6: peripheral index 0 reflects the DMA bank only
    assert_peri0_dma_R6: assert property (@(posedge clk) disable iff (rst)
        (peri_v && peri_i == '0) |-> dma_valid);
endmodule

// File: tb/tb_hirq_status_unit.sv
module tb_hirq_status_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  crit_src = '0;
    logic [16:0] main_src = '0;
    logic [31:0] peri_src = '0;
    logic [31:0] dma_req = '0;
    logic        irq_req;
    logic [1:0]  irq_class;
    logic        dma_valid;
    logic [4:0]  dma_idx;

    hirq_status_unit dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .crit_src(crit_src),
        .main_src(main_src), .peri_src(peri_src), .dma_req(dma_req),
        .irq_req(irq_req), .irq_class(irq_class), .dma_valid(dma_valid),
        .dma_idx(dma_idx)
    );

    always #10 clk = ~clk;   // 50 MHz

    localparam int SEL_RD  = 0;   // reg_rdata
    localparam int SEL_IRQ = 1;   // {irq_req, irq_class}
    localparam int SEL_DMA = 2;   // {dma_valid, dma_idx}

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compare each expected item against the live outputs
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [31:0] obs;
            it = q.pop_front();
            case (it.sel)
                SEL_RD:  obs = reg_rdata;
                SEL_IRQ: obs = {29'b0, irq_req, irq_class};
                default: obs = {26'b0, dma_valid, dma_idx};
            endcase
            checks++;
            if (obs !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, obs, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic chk(input int sel, input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(SEL_RD, 3'd1, 32'h0001FFFF, "R1 main mask in reset");
        rst = 1'b0;
        @(negedge clk);
        // ---- R1 reset state ----
        chk(SEL_RD, 3'd0, 32'h0, "R1 status");
        chk(SEL_RD, 3'd1, 32'h0001FFFF, "R1 main mask");
        chk(SEL_RD, 3'd2, 32'hFFFFFFFF, "R1 peri mask");
        chk(SEL_RD, 3'd3, 32'h0, "R1 dma pend");
        chk(SEL_RD, 3'd4, 32'hFFFFFFFF, "R1 dma mask");
        chk(SEL_IRQ, 3'd0, 32'h0, "R1 irq idle");

        // ---- R3 main group ----
        main_src = (17'd1 << 5) | (17'd1 << 9);
        chk(SEL_RD, 3'd0, 32'h0, "R3 masked main");
        wr(3'd1, 32'h0001FF7F);                       // enable idx 9 (bit 7)
        chk(SEL_RD, 3'd0, 32'h00290000, "R3 main idx9");
        wr(3'd1, 32'h0001F77F);                       // enable idx 5 (bit 11)
        chk(SEL_RD, 3'd0, 32'h00250000, "R3 main lowest idx5");
        chk(SEL_IRQ, 3'd0, 32'h6, "R9 class main");
        wr(3'd1, 32'hFFFFFFFF);
        chk(SEL_RD, 3'd1, 32'h0001FFFF, "R10 main mask upper bits");
        wr(3'd1, 32'h0001F77F);
        chk(SEL_RD, 3'd1, 32'h0001F77F, "R10 main mask readback");
        main_src = '0;

        // ---- R4 peripheral group, R7 cascade ----
        peri_src = (32'd1 << 7) | (32'd1 << 20);
        chk(SEL_RD, 3'd0, 32'h0, "R4 masked peri");
        wr(3'd2, 32'hFFFFF7FF);                       // enable idx 20 (bit 11)
        chk(SEL_RD, 3'd0, 32'h34000000, "R4 peri idx20");
        chk(SEL_IRQ, 3'd0, 32'h5, "R9 class peri");
        wr(3'd1, 32'h0001E77F);                       // enable main idx 4 (bit 12)
        chk(SEL_RD, 3'd0, 32'h34240000, "R7 cascade to main4");
        wr(3'd5, 32'h1);
        chk(SEL_RD, 3'd5, 32'h1, "R10 ctrl readback");
        chk(SEL_RD, 3'd0, 32'h34000600, "R7 cascade to crit2");
        chk(SEL_IRQ, 3'd0, 32'h7, "R9 class crit");
        wr(3'd5, 32'h0);
        peri_src = '0;
        main_src = 17'd1 << 4;
        chk(SEL_RD, 3'd0, 32'h0, "R7 main_src4 ignored");
        main_src = '0;

        // ---- R5/R6 DMA bank ----
        dma_req = (32'd1 << 3) | (32'd1 << 12);
        @(negedge clk);
        dma_req = '0;
        chk(SEL_RD, 3'd3, 32'h00001008, "R5 dma latch");
        chk(SEL_DMA, 3'd0, 32'h0, "R6 dma masked");
        wr(3'd4, 32'hFFFFEFFF);
        chk(SEL_DMA, 3'd0, 32'h2C, "R6 dma idx12");
        chk(SEL_RD, 3'd4, 32'hFFFFEFFF, "R10 dma mask readback");
        chk(SEL_RD, 3'd0, 32'h0, "R6 peri0 masked");
        wr(3'd2, 32'h7FFFF7FF);
        chk(SEL_RD, 3'd0, 32'h20240000, "R6 dma drives peri0");
        wr(3'd3, 32'h00001000);
        chk(SEL_RD, 3'd3, 32'h00000008, "R5 w1c");
        chk(SEL_DMA, 3'd0, 32'h0, "R6 remaining bit masked");
        chk(SEL_RD, 3'd0, 32'h0, "R6 peri0 gone");
        dma_req = 32'd1 << 5;
        @(negedge clk);
        wr(3'd3, 32'h00000020);
        chk(SEL_RD, 3'd3, 32'h00000028, "R5 request beats clear");
        dma_req = '0;
        @(negedge clk);
        wr(3'd3, 32'h00000028);
        chk(SEL_RD, 3'd3, 32'h0, "R5 cleared");
        peri_src = 32'h1;
        chk(SEL_RD, 3'd0, 32'h0, "R6 peri_src0 ignored");
        peri_src = '0;

        // ---- R2/R8 critical group ----
        crit_src = 4'b1010;
        @(negedge clk);
        crit_src = '0;
        chk(SEL_RD, 3'd0, 32'h00000500, "R2 crit idx1");
        chk(SEL_IRQ, 3'd0, 32'h7, "R9 class crit latched");
        wr(3'd0, 32'h00000400);
        chk(SEL_RD, 3'd0, 32'h00000700, "R8 ack idx1 leaves idx3");
        wr(3'd0, 32'h0);
        chk(SEL_RD, 3'd0, 32'h00000700, "R8 write without bit10");
        wr(3'd0, 32'h00000400);
        chk(SEL_RD, 3'd0, 32'h0, "R8 ack idx3");
        crit_src = 4'b0100;
        @(negedge clk);
        crit_src = '0;
        chk(SEL_RD, 3'd0, 32'h0, "R7 crit_src2 ignored");
        chk(SEL_IRQ, 3'd0, 32'h0, "R9 idle again");

        @(negedge clk);
        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule